// File: doc/BRIEF.md
# Scanline-Clocked Serial Gamepad Receiver

This block reads the button state of a parallel-in/serial-out gamepad without a timer of its own. The video timing's vertical sync is passed on to the pad as its load strobe, so the pad freezes its buttons once per frame. Horizontal sync is passed on as the pad's shift clock. On every rising active edge of horizontal sync the receiver also takes in one serial bit, so one bit arrives per scanline.

The shift register and the parallel output register are clocked by the same horizontal sync event. The parallel output therefore changes on every scanline and trails the shift register by one line. A processor reads the parallel value during vertical blank. It gets the whole button byte only on the one scanline where that byte lines up; a read on any other line returns the byte shifted by the number of lines it is off. Both sync inputs and the serial line are brought into the system clock domain by a parameterised synchronizer chain.

Top module: `gpad_rx`

## Requirements
- R1: While reset is asserted, and until the first horizontal sync edge after reset, `pad_bits_o` is all ones and `pad_latch_o` and `pad_clock_o` are 0.
- R2: `pad_clock_o` and `pad_latch_o` are the active-high forms of horizontal and vertical sync. Each goes high SYNC_STAGES+1 clock edges after its raw sync input goes active. With the default settings the raw sync inputs are active-low.
- R3: Each rising active edge of horizontal sync shifts the register by one place. The serial bit goes into bit 0 and every older bit moves one place toward the MSB.
- R4: With TIED_STORE=1 (the default), the same horizontal sync edge copies the contents the shift register had before that shift into `pad_bits_o`, so the output trails the shift register by one scanline.
- R5: The pad sends the first bit after its load as the MSB of its button byte. After one vertical sync pulse and then nine horizontal sync pulses, `pad_bits_o` equals that byte.
- R6: Buttons are active-low. With no button pressed, the aligned read returns 0xFF.
- R7: Holding horizontal sync active for many clocks, and its return to inactive, leave `pad_bits_o` unchanged.
- R8: A vertical sync pulse with no horizontal edge leaves `pad_bits_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_i | input | 1 | Raw vertical sync from the video timing |
| hsync_i | input | 1 | Raw horizontal sync from the video timing |
| pad_data_i | input | 1 | Serial data from the gamepad |
| pad_latch_o | output | 1 | Load strobe to the gamepad, active high |
| pad_clock_o | output | 1 | Shift clock to the gamepad, active high |
| pad_bits_o | output | WIDTH | Parallel button value read by the processor |

## Verification
A raw sync edge reaches `pad_clock_o` and `pad_bits_o` three clock edges after it is driven, because two synchronizer stages and the edge register lie on the way. The bench probes one edge before that and one edge after it. After that, every pulse task holds the sync level for five clocks and then waits five more, so all checks sample settled values midway between clock edges. The sweep goes through all 256 button bytes. Before each pulse the bench computes the expected shift and output contents from the count of horizontal pulses since the last load. The output is compared after every one of the nine pulses, and two extra pulses check the misaligned reads.

// File: rtl/gpad_pkg.sv
package gpad_pkg;

   // Synchronised sync line: settled level and a one-cycle rising pulse.
   typedef struct packed {
      logic level;
      logic rise;
   } gpad_sync_t;

   localparam int unsigned GPAD_MAX_SYNC = 4;

endpackage

// File: rtl/gpad_sync_edge.sv
module gpad_sync_edge
   import gpad_pkg::*;
#(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       raw_i,
   output gpad_sync_t sync_o
);

   logic              active;
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   assign active = raw_i ^ ACTIVE_LOW;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= active;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], active};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign sync_o.level = prev_q;
   assign sync_o.rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/gpad_shift_stage.sv
module gpad_shift_stage #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             serial_i,
   input  logic             shift_en_i,
   output logic             serial_s_o,
   output logic [WIDTH-1:0] shift_o
);

   logic [STAGES-1:0] dsync_q;
   logic [WIDTH-1:0]  shift_q;

   // The serial line idles high, so the chain resets to ones.
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) dsync_q <= '1;
            else     dsync_q <= serial_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) dsync_q <= '1;
            else     dsync_q <= {dsync_q[STAGES-2:0], serial_i};
         end
      end
   endgenerate

   assign serial_s_o = dsync_q[STAGES-1];

   always_ff @(posedge clk) begin
      if (rst)             shift_q <= '1;
      else if (shift_en_i) shift_q <= {shift_q[WIDTH-2:0], serial_s_o};
   end

   assign shift_o = shift_q;

endmodule

// File: rtl/gpad_store_stage.sv
module gpad_store_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)         hold_q <= '1;
      else if (load_i) hold_q <= d_i;
   end

   assign q_o = hold_q;

endmodule

// File: rtl/gpad_rx.sv
module gpad_rx
   import gpad_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HSYNC_ACT_LO = 1'b1,
   parameter bit          VSYNC_ACT_LO = 1'b1,
   parameter bit          TIED_STORE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vsync_i,
   input  logic             hsync_i,
   input  logic             pad_data_i,
   output logic             pad_latch_o,
   output logic             pad_clock_o,
   output logic [WIDTH-1:0] pad_bits_o
);

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gpad_rx: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > GPAD_MAX_SYNC) begin : g_bad_sync
         $error("gpad_rx: SYNC_STAGES out of range");
      end
   endgenerate

   gpad_sync_t     hs_s;
   gpad_sync_t     vs_s;
   logic           data_s;
   logic [MSB:0]   shift_q;

   gpad_sync_edge #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(HSYNC_ACT_LO)) hs_sync_i (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (hsync_i),
      .sync_o (hs_s)
   );

   gpad_sync_edge #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(VSYNC_ACT_LO)) vs_sync_i (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (vsync_i),
      .sync_o (vs_s)
   );

   gpad_shift_stage #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) shift_i (
      .clk        (clk),
      .rst        (rst),
      .serial_i   (pad_data_i),
      .shift_en_i (hs_s.rise),
      .serial_s_o (data_s),
      .shift_o    (shift_q)
   );

   // The registered level rises on the same edge that samples the data,
   // so the pad moves its next bit out only after the bit was taken.
   assign pad_clock_o = hs_s.level;
   assign pad_latch_o = vs_s.level;

   generate
      if (TIED_STORE) begin : g_tied
         gpad_store_stage #(.WIDTH(WIDTH)) store_i (
            .clk    (clk),
            .rst    (rst),
            .load_i (hs_s.rise),
            .d_i    (shift_q),
            .q_o    (pad_bits_o)
         );
      end else begin : g_direct
         assign pad_bits_o = shift_q;
      end
   endgenerate

endmodule

// File: rtl/gpad_rx_checker.sv
module gpad_rx_checker #(
   parameter int unsigned WIDTH      = 8,
   parameter bit          TIED_STORE = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             hs_rise,
   input logic             vs_rise,
   input logic             data_s,
   input logic [WIDTH-1:0] shift_q,
   input logic             pad_clock_o,
   input logic [WIDTH-1:0] pad_bits_o
);

   // R2: the pad clock goes high right after a detected edge, never otherwise
   a_r2_clock_follows: assert property (@(posedge clk) disable iff (rst)
      hs_rise |=> pad_clock_o);
   a_r2_clock_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(pad_clock_o) |-> $past(hs_rise));

   // R3: one place per edge, new bit into bit 0
   a_r3_one_bit_shift: assert property (@(posedge clk) disable iff (rst)
      hs_rise |=> (shift_q == {$past(shift_q[WIDTH-2:0]), $past(data_s)}));

   // R7: no edge, no change anywhere in the register path
   a_r7_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
      !hs_rise |=> ($stable(shift_q) && $stable(pad_bits_o)));

   // R8: a frame strobe on its own leaves the output alone
   a_r8_vsync_no_effect: assert property (@(posedge clk) disable iff (rst)
      (vs_rise && !hs_rise) |=> $stable(pad_bits_o));

   generate
      if (TIED_STORE) begin : g_lag
         // R4: output takes the pre-shift contents
         a_r4_store_lags: assert property (@(posedge clk) disable iff (rst)
            hs_rise |=> (pad_bits_o == $past(shift_q)));
      end
   endgenerate

endmodule

bind gpad_rx gpad_rx_checker #(.WIDTH(WIDTH), .TIED_STORE(TIED_STORE)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .hs_rise     (hs_s.rise),
   .vs_rise     (vs_s.rise),
   .data_s      (data_s),
   .shift_q     (shift_q),
   .pad_clock_o (pad_clock_o),
   .pad_bits_o  (pad_bits_o)
);

// File: tb/gpad_rx_tb_top.sv
module gpad_rx_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       vsync_i;
   logic       hsync_i;
   logic       pad_data_i;
   logic       pad_latch_o;
   logic       pad_clock_o;
   logic [7:0] pad_bits_o;

   int unsigned n_vec  = 0;
   int unsigned n_fail = 0;

   // Independent expectation state
   logic [7:0]  exp_sh;
   logic [7:0]  exp_out;
   logic [7:0]  stub_byte;
   int unsigned bits_since_load;

   // Pad stub: loads on its strobe, shifts on its clock, ones shift in behind
   logic [7:0] pad_sr = 8'hFF;
   always @(posedge pad_latch_o or posedge pad_clock_o) begin
      if (pad_latch_o) pad_sr <= stub_byte;
      else             pad_sr <= {pad_sr[6:0], 1'b1};
   end
   assign pad_data_i = pad_sr[7];

   always #2 clk = ~clk;

   gpad_rx dut_i (
      .clk         (clk),
      .rst         (rst),
      .vsync_i     (vsync_i),
      .hsync_i     (hsync_i),
      .pad_data_i  (pad_data_i),
      .pad_latch_o (pad_latch_o),
      .pad_clock_o (pad_clock_o),
      .pad_bits_o  (pad_bits_o)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   function automatic logic next_bit();
      return (bits_since_load < 8) ? stub_byte[7 - bits_since_load] : 1'b1;
   endfunction

   task automatic model_shift();
      logic b;
      b       = next_bit();
      exp_out = exp_sh;
      exp_sh  = {exp_sh[6:0], b};
      bits_since_load++;
   endtask

   task automatic hpulse();
      model_shift();
      hsync_i = 1'b0;
      tick(5);
      hsync_i = 1'b1;
      tick(5);
   endtask

   task automatic vpulse();
      vsync_i = 1'b0;
      tick(5);
      vsync_i = 1'b1;
      tick(5);
      bits_since_load = 0;
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; vsync_i = 1'b1; hsync_i = 1'b1;
      stub_byte = 8'hFF; exp_sh = 8'hFF; exp_out = 8'hFF; bits_since_load = 8;
      tick(4);
      // R1: reset values
      check("R1 bits", pad_bits_o, 8'hFF);
      check("R1 latch", {7'd0, pad_latch_o}, 8'd0);
      check("R1 clock", {7'd0, pad_clock_o}, 8'd0);
      rst = 1'b0;
      tick(3);
      check("R1 bits after release", pad_bits_o, 8'hFF);

      // R2: sync-to-pad latency, probed one edge early and on time
      stub_byte = 8'hA5;
      vsync_i = 1'b0;
      tick(2);
      check("R2 latch early", {7'd0, pad_latch_o}, 8'd0);
      tick(1);
      check("R2 latch due", {7'd0, pad_latch_o}, 8'd1);
      tick(2);
      vsync_i = 1'b1;
      tick(5);
      bits_since_load = 0;
      check("R8 vsync alone", pad_bits_o, exp_out);

      model_shift();
      hsync_i = 1'b0;
      tick(2);
      check("R2 clock early", {7'd0, pad_clock_o}, 8'd0);
      tick(1);
      check("R2 clock due", {7'd0, pad_clock_o}, 8'd1);
      check("R4 same-edge store", pad_bits_o, exp_out);
      // R7: long active hold and release do nothing further
      tick(20);
      check("R7 held active", pad_bits_o, exp_out);
      hsync_i = 1'b1;
      tick(10);
      check("R7 after release", pad_bits_o, exp_out);

      // Sweep every button byte: R3 per line, R4 lag, R5 aligned read
      for (int v = 0; v < 256; v++) begin
         stub_byte = v[7:0];
         vpulse();
         check("R8 vsync pulse", pad_bits_o, exp_out);
         for (int p = 1; p <= 9; p++) begin
            hpulse();
            check("R3 per-scanline", pad_bits_o, exp_out);
         end
         check("R5 aligned read", pad_bits_o, v[7:0]);
         if (v == 255) check("R6 idle pad", pad_bits_o, 8'hFF);
         if (v[4:0] == 5'd3) begin
            for (int p = 0; p < 2; p++) begin
               hpulse();
               check("R3 misaligned read", pad_bits_o,
                     8'((v << (p + 1)) | ((1 << (p + 1)) - 1)));
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule